// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets logic running on a system clock read and write an external asynchronous static RAM of 128K bytes. The host side presents one request at a time: a read/write flag, a 17-bit byte address and, for writes, a data byte. The block answers each request with a one-clock acknowledge. For a read, the captured byte appears on the read-data port in that acknowledge cycle.

On the memory side the block drives both chip selects: the one that is active when low and the one that is active when high. It also drives the write strobe and the output-enable strobe, which are both active-low, plus the outgoing data and a data-drive enable for the pad. The strobes and enables come straight from flops. A write is ended by the rising write strobe. The block keeps the address steady while the chip is selected, and it drives data only while the RAM's outputs are switched off. Three parameters turn the nanosecond limits into clock counts: the read wait, the write pulse length, and the setup gap before the strobe falls. Between any two requests the block returns to an idle state with the chip deselected.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset the memory pins idle as follows: low-active select = 1, high-active select = 0, write strobe = 1, output strobe = 1, data drive = 0. The acknowledge is 0.
- R2: A write selects the chip with the write strobe high for BUS_GAP cycles. It then holds the strobe low for exactly WE_PULSE cycles, with the data driven for all of that time.
- R3: The data-drive enable is never 1 while the output strobe is low.
- R4: The memory address never changes while the chip is selected.
- R5: A read holds the output strobe low for RD_WAIT cycles, with the write strobe high and the drive off. The byte on the data input at the end of that window appears on the read-data port from the acknowledge cycle onward. It stays there until the next read completes, and writes do not change it.
- R6: Each transaction gets exactly one acknowledge cycle. Count the first cycle after acceptance as cycle 1. A write is acknowledged in cycle BUS_GAP+WE_PULSE+1 and a read in cycle RD_WAIT+1.
- R7: In the cycle after an acknowledge the chip is deselected and the acknowledge is 0, even if a request is already waiting. Requests are accepted only in that idle state.
- R8: Address, data and direction are taken at acceptance. Changing them while a transaction is in progress has no effect on it.
- R9: During the write's acknowledge cycle the write strobe is high, but the write byte is still driven, so data is held past the strobe's rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_sel | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
Two things can land in the same cycle: the completion of one transaction and the arrival of the next request. The bench sets this up by holding the request line high across an acknowledge. It then checks that the following cycle is a deselected idle cycle and that the chip is selected again only one cycle after that. A bench memory model watches the bus on every cycle for overlap between its own drive and the block's drive. It also checks for address movement while the chip is selected and for write strobe pulses of the wrong length.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_W_SETUP = 3'd1,
    ST_W_PULSE = 3'd2,
    ST_W_DONE  = 3'd3,
    ST_R_WAIT  = 3'd4,
    ST_R_DONE  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic ack;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1,
                                     oe_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};

  // Pin levels that each state presents to the memory and the host.
  function automatic pin_set_t pins_for(seq_state_e s);
    pin_set_t p;
    p = PINS_IDLE;
    if (s != ST_IDLE) begin
      p.sel_n = 1'b0;
      p.sel   = 1'b1;
    end
    case (s)
      ST_W_PULSE: begin p.we_n = 1'b0; p.dq_oe = 1'b1; end
      ST_W_DONE:  begin p.dq_oe = 1'b1; p.ack = 1'b1; end
      ST_R_WAIT:  p.oe_n = 1'b0;
      ST_R_DONE:  p.ack = 1'b1;
      default:    ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_port_pkg::*;
#(
  parameter int RD_WAIT  = 3,
  parameter int WE_PULSE = 2,
  parameter int BUS_GAP  = 1,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expire,
  output logic             accept,
  output logic             capture,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output pin_set_t         pins
);

  seq_state_e state_q, state_d;
  pin_set_t   pins_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid) state_d = req_write ? ST_W_SETUP : ST_R_WAIT;
      ST_W_SETUP: if (expire) state_d = ST_W_PULSE;
      ST_W_PULSE: if (expire) state_d = ST_W_DONE;
      ST_W_DONE:  state_d = ST_IDLE;
      ST_R_WAIT:  if (expire) state_d = ST_R_DONE;
      ST_R_DONE:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_W_SETUP: load_val = CNT_W'(BUS_GAP - 1);
      ST_W_PULSE: load_val = CNT_W'(WE_PULSE - 1);
      ST_R_WAIT:  load_val = CNT_W'(RD_WAIT - 1);
      default:    load_val = '0;
    endcase
  end

  assign load    = (state_d != state_q);
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign capture = (state_q == ST_R_WAIT) && expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pins_q  <= PINS_IDLE;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_for(state_d);
    end
  end

  assign pins = pins_q;

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int RD_WAIT  = 3,
  parameter int WE_PULSE = 2,
  parameter int BUS_GAP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAX_A = (RD_WAIT > WE_PULSE) ? RD_WAIT : WE_PULSE;
  localparam int MAX_C = (MAX_A > BUS_GAP) ? MAX_A : BUS_GAP;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             accept, capture, load, expire;
  logic [CNT_W-1:0] load_val;
  pin_set_t         pins;

  sram_seq_fsm #(
    .RD_WAIT(RD_WAIT), .WE_PULSE(WE_PULSE), .BUS_GAP(BUS_GAP), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .expire(expire), .accept(accept), .capture(capture), .load(load),
    .load_val(load_val), .pins(pins)
  );

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expire(expire)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rsp_rdata(rsp_rdata)
  );

  assign mem_sel_n = pins.sel_n;
  assign mem_sel   = pins.sel;
  assign mem_we_n  = pins.we_n;
  assign mem_oe_n  = pins.oe_n;
  assign mem_dq_oe = pins.dq_oe;
  assign req_ack   = pins.ack;

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int ADDR_W   = 17,
  parameter int WE_PULSE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run_q <= '0;
    else if (!mem_we_n) we_run_q <= we_run_q + 1'b1;
    else                we_run_q <= '0;
  end

  assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run_q == 16'(WE_PULSE)));

  assert_we_while_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel && mem_dq_oe));

  assert_no_drive_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |=> (mem_sel_n || $stable(mem_addr)));

  assert_read_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_sel_n));

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  assert_idle_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (mem_sel_n && !mem_sel));

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W), .WE_PULSE(WE_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .mem_addr(mem_addr),
  .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_port_ctrl_bench.sv
`timescale 1ns/1ps
module sram_port_ctrl_bench;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int RW = 3;
  localparam int WP = 2;
  localparam int GP = 1;
  localparam int CLK_NS = 5;
  localparam int SETUP_NS = 6;

  logic          clk, rst_n;
  logic          req_valid, req_write, req_ack;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
  logic          mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;

  sram_port_ctrl #(.RD_WAIT(RW), .WE_PULSE(WP), .BUS_GAP(GP)) u_sram_port_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
    .mem_sel(mem_sel), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // ---------------- memory model ----------------
  logic [DW-1:0] mem_m [int];
  logic [DW-1:0] model_q = '0;
  logic [DW-1:0] dq_prev = '0;
  logic [AW-1:0] addr_prev = '0;
  bit   sel_prev = 1'b0;
  bit   we_prev_low = 1'b0;
  int   we_cnt = 0, oe_cnt = 0;
  int   err_clash = 0, err_addr = 0, err_width = 0, err_oe = 0, err_hold = 0;

  wire chip_on     = !mem_sel_n && mem_sel;
  wire model_drive = chip_on && !mem_oe_n && mem_we_n;
  assign mem_dq_in = model_drive ? model_q : 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (model_drive && mem_dq_oe) err_clash++;
      if (chip_on && sel_prev && mem_addr != addr_prev) err_addr++;
      if (chip_on && !mem_oe_n) begin
        model_q = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
        oe_cnt++;
      end else if (oe_cnt != 0) begin
        if (oe_cnt < RW) err_oe++;
        oe_cnt = 0;
      end
      if (!mem_we_n) begin
        if (!mem_dq_oe) err_hold++;
        if (we_cnt > 0 && mem_dq_out != dq_prev) err_hold++;
        we_cnt++;
      end else if (we_prev_low) begin
        if (!mem_dq_oe) err_hold++;
        if (we_cnt != WP || we_cnt * CLK_NS < SETUP_NS) err_width++;
        mem_m[int'(mem_addr)] = mem_dq_out;
        we_cnt = 0;
      end
      we_prev_low = !mem_we_n;
      sel_prev    = chip_on;
      addr_prev   = mem_addr;
      dq_prev     = mem_dq_out;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  int last_lat, last_pre, last_we_lo;
  bit last_hold;
  logic [DW-1:0] last_rd;

  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit scramble);
    int lat;
    lat = 0; last_pre = 0; last_we_lo = 0; last_hold = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      lat++;
      if (scramble && lat == 1) begin
        req_addr = a ^ 17'h1; req_wdata = ~d; req_write = ~wr;
      end
      if (!mem_we_n) last_we_lo++;
      else if (last_we_lo == 0 && chip_on) last_pre++;
      if (req_ack) begin
        last_hold = mem_dq_oe && mem_we_n && (mem_dq_out == d);
        last_rd = rsp_rdata;
        break;
      end
      if (lat > 100) break;
    end
    last_lat = lat;
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ack && mem_sel_n && !mem_sel, "R7 idle after ack",
          {req_ack, mem_sel_n, mem_sel}, 3'b010);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check({mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, req_ack} == 6'b101100,
          "R1 reset pins", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, req_ack},
          6'b101100);
  endtask

  task automatic t_patterns();
    logic [AW-1:0] al [5] = '{17'h00000, 17'h1FFFF, 17'h0AAAA, 17'h15555, 17'h00100};
    logic [DW-1:0] dl [5] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h3C};
    for (int i = 0; i < 5; i++) begin
      run_txn(1'b1, al[i], dl[i], 1'b0);
      check(last_lat == GP + WP + 1, "R6 write ack cycle", last_lat, GP + WP + 1);
      if (i == 0) begin
        check(last_pre == GP, "R2 select before strobe", last_pre, GP);
        check(last_we_lo == WP, "R2 strobe low cycles", last_we_lo, WP);
        check(last_hold, "R9 data held at strobe rise", last_hold, 1);
      end
    end
    for (int i = 0; i < 5; i++) begin
      run_txn(1'b0, al[i], 8'h00, 1'b0);
      check(last_lat == RW + 1, "R6 read ack cycle", last_lat, RW + 1);
      check(last_rd == dl[i], "R5 read data", last_rd, dl[i]);
    end
  endtask

  task automatic t_ignore();
    run_txn(1'b1, 17'h00040, 8'h11, 1'b0);
    run_txn(1'b1, 17'h00041, 8'h22, 1'b0);
    run_txn(1'b1, 17'h00040, 8'h77, 1'b1);
    run_txn(1'b0, 17'h00040, 8'h00, 1'b0);
    check(last_rd == 8'h77, "R8 taken at accept", last_rd, 8'h77);
    run_txn(1'b0, 17'h00041, 8'h00, 1'b0);
    check(last_rd == 8'h22, "R8 other address untouched", last_rd, 8'h22);
    run_txn(1'b0, 17'h00040, 8'h00, 1'b1);
    check(last_lat == RW + 1 && last_rd == 8'h77, "R8 read not turned to write",
          last_rd, 8'h77);
  endtask

  task automatic t_rdata_hold();
    run_txn(1'b0, 17'h1FFFF, 8'h00, 1'b0);
    run_txn(1'b1, 17'h00007, 8'hC3, 1'b0);
    repeat (3) @(negedge clk);
    check(rsp_rdata == 8'hFF, "R5 read data held over write", rsp_rdata, 8'hFF);
  endtask

  task automatic t_back_to_back();
    int lat;
    lat = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h0AAAA;
    do begin @(negedge clk); lat++; end while (!req_ack && lat < 100);
    @(negedge clk);
    check(mem_sel_n && !mem_sel && !req_ack, "R7 idle despite waiting request",
          {mem_sel_n, mem_sel}, 2'b10);
    @(negedge clk);
    check(!mem_sel_n && mem_sel && !mem_oe_n, "R7 accepted from idle",
          {mem_sel_n, mem_oe_n}, 2'b00);
    req_valid = 1'b0;
    lat = 1;
    do begin @(negedge clk); lat++; end while (!req_ack && lat < 100);
    check(lat == RW + 1 && rsp_rdata == 8'h55, "R6 second read", rsp_rdata, 8'h55);
    @(negedge clk);
  endtask

  task automatic t_model_audit();
    check(err_clash == 0, "R3 bus overlap cycles", err_clash, 0);
    check(err_addr == 0, "R4 address moved while selected", err_addr, 0);
    check(err_width == 0, "R2 strobe width or setup", err_width, 0);
    check(err_hold == 0, "R9 data not held during write", err_hold, 0);
    check(err_oe == 0, "R5 output strobe too short", err_oe, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_ignore();
    t_rdata_hold();
    t_back_to_back();
    t_model_audit();
    finish_run();
  end

endmodule